// File: doc/BRIEF.md
# UART Register Bank with Interrupt Cause Latching

This block is the software-visible face of a UART. It presents eight 32-bit word registers on a simple bus that completes every access in one cycle. Through these registers software sets the frame format, the flow-control options and the FIFO trigger levels. It reads a packed status word and moves characters in and out of the FIFOs. The block also drives the ready-to-send line and the FIFO flush strobes.

A read of the data word pops one character from the receive FIFO. A write of the data word pushes one character into the transmit FIFO. Both happen through strobes that last as long as the access. The shift engine and the FIFO storage live outside the block; they connect through level inputs, error flags and a vector of raw interrupt events.

Each raw event is latched on its rising edge into a cause bit. The cause bit stays set until software writes a one to it. The single interrupt line is the OR of all cause bits that are both latched and enabled in the mask register.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the control, mask, trigger and command registers read 0, every cause bit is clear, and irq, rts, rx_fifo_clr and tx_fifo_clr are 0.
- R2: Word offset 0x00 is the control register. Only bits 0-5 and 22-24 are stored; every other bit reads 0. Bit 0 drives ctl_enable and bit 1 drives ctl_eight_bits. Bit 2 drives ctl_two_stop, bit 3 drives ctl_par_en and bits 5:4 drive ctl_par_kind. Bit 22 drives ctl_dma_en, bit 23 drives ctl_flow_en and bit 24 drives ctl_loop.
- R3: Offset 0x04 reads a packed status word, and writes to it are ignored. Bits 6:0 hold rx_level and bits 12:8 hold tx_room. Bit 14 is tx_busy, bit 15 rx_busy, bit 16 rx_ovf and bit 17 tx_ovf. Bit 18 is rx_par_err, bit 19 rx_frm_err and bit 25 cts_in. All other bits read 0.
- R4: A read of offset 0x08 returns rx_char in the low bits and holds rx_pop high during that access cycle. A write of offset 0x08 holds tx_push high with tx_char equal to the low bits of the written data, and leaves rx_pop low.
- R5: Offset 0x14 holds the trigger levels and stores only bits 4:0, 11:8 and 20:16. These fields drive trig_rx, trig_tx and trig_afc in that order.
- R6: A cause bit sets on the clock edge after a 0-to-1 transition of its irq_evt bit. An event input that stays high does not set the cause again once it has been cleared.
- R7: Offset 0x0C is the enable mask; source i uses bit i, and only bits below the source count are stored. A read of offset 0x10 returns the latched-and-enabled causes in bits 9:0 and all latched causes in bits 25:16.
- R8: Writing offset 0x10 clears every cause bit whose position has a 1 in either half of the written word. A rising edge in the same cycle as the clear keeps the cause set.
- R9: irq is high exactly when some latched cause is also enabled. Clearing its mask bit drops irq without clearing the cause.
- R10: Bit 5 of the command registers is rts. Writing 1 to bit 5 at offset 0x18 sets it, and writing 1 to bit 5 at offset 0x1C clears it. Both offsets read back the command state.
- R11: Writing 1 to bit 6 (or bit 7) at offset 0x18 raises rx_fifo_clr (or tx_fifo_clr) for exactly the next cycle. These bits then read back 0. Writing them at offset 0x1C has no effect.
- R12: An access whose two low address bits are not zero has no effect: no register changes, no strobe fires, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_char | input | CHAR_W | Head of the receive FIFO |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_char | output | CHAR_W | Character to push |
| rx_level | input | RXL_W | Receive FIFO fill level |
| tx_room | input | TXL_W | Transmit FIFO field |
| tx_busy | input | 1 | Transmitter active |
| rx_busy | input | 1 | Receiver active |
| rx_ovf | input | 1 | Receive overflow flag |
| tx_ovf | input | 1 | Transmit overflow flag |
| rx_par_err | input | 1 | Parity error flag |
| rx_frm_err | input | 1 | Framing error flag |
| cts_in | input | 1 | Clear-to-send line state |
| irq_evt | input | N_SRC | Raw interrupt events |
| ctl_enable | output | 1 | UART enable |
| ctl_eight_bits | output | 1 | Eight data bits |
| ctl_two_stop | output | 1 | Two stop bits |
| ctl_par_en | output | 1 | Parity enable |
| ctl_par_kind | output | 2 | Parity type |
| ctl_dma_en | output | 1 | DMA enable |
| ctl_flow_en | output | 1 | Hardware flow control enable |
| ctl_loop | output | 1 | Loopback enable |
| trig_rx | output | 5 | Receive trigger level |
| trig_tx | output | 4 | Transmit trigger level |
| trig_afc | output | 5 | Automatic flow-control level |
| rts | output | 1 | Ready-to-send state |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO flush |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO flush |
| irq | output | 1 | Interrupt request |

## Verification
Read data, rx_pop, tx_push and tx_char are combinational. They are due in the same cycle as the access, so the bench samples them 1 ns after driving the access, before the next rising edge.

Register writes, cause latching and the flush pulses take effect at the first rising edge after the stimulus. The bench drives on falling edges and checks these results at the following falling edge. It checks flush pulses once more one cycle later, to confirm they are gone.

irq is combinational from registered state. It is therefore checked in the same falling-edge window as the register it depends on.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

   typedef enum logic [2:0] {
      RS_CTRL  = 3'd0,
      RS_STAT  = 3'd1,
      RS_DATA  = 3'd2,
      RS_MASK  = 3'd3,
      RS_CAUSE = 3'd4,
      RS_TRIG  = 3'd5,
      RS_CSET  = 3'd6,
      RS_CCLR  = 3'd7
   } rb_sel_e;

   localparam int unsigned NUM_REGS   = 8;
   localparam int unsigned WORD_W     = 32;

   // control field positions
   localparam int unsigned CB_EN      = 0;
   localparam int unsigned CB_DB8     = 1;
   localparam int unsigned CB_STOP2   = 2;
   localparam int unsigned CB_PEN     = 3;
   localparam int unsigned CB_PKIND   = 4;
   localparam int unsigned CB_DMA     = 22;
   localparam int unsigned CB_FLOW    = 23;
   localparam int unsigned CB_LOOP    = 24;
   localparam logic [31:0] CTRL_KEEP  = 32'h01C0_003F;

   // trigger field positions
   localparam int unsigned TB_RX      = 0;
   localparam int unsigned TB_TX      = 8;
   localparam int unsigned TB_AFC     = 16;
   localparam logic [31:0] TRIG_KEEP  = 32'h001F_0F1F;

   // status field positions
   localparam int unsigned SB_RXLVL   = 0;
   localparam int unsigned SB_TXLVL   = 8;
   localparam int unsigned SB_TXBSY   = 14;
   localparam int unsigned SB_RXBSY   = 15;
   localparam int unsigned SB_RXOVF   = 16;
   localparam int unsigned SB_TXOVF   = 17;
   localparam int unsigned SB_PAR     = 18;
   localparam int unsigned SB_FRM     = 19;
   localparam int unsigned SB_CTS     = 25;

   // command bits (the command module receives bits [CMD_LO +: 3])
   localparam int unsigned CMD_LO     = 5;
   localparam int unsigned CMD_RTS    = 5;
   localparam int unsigned CMD_RXRST  = 6;
   localparam int unsigned CMD_TXRST  = 7;

   // raw half of the cause register
   localparam int unsigned CAUSE_RAW  = 16;

endpackage

// File: rtl/uart_rb_stat.sv
module uart_rb_stat #(
   parameter int unsigned RXL_W = 7,
   parameter int unsigned TXL_W = 5
) (
   input  logic [RXL_W-1:0] rx_level,
   input  logic [TXL_W-1:0] tx_room,
   input  logic             tx_busy,
   input  logic             rx_busy,
   input  logic             rx_ovf,
   input  logic             tx_ovf,
   input  logic             rx_par_err,
   input  logic             rx_frm_err,
   input  logic             cts_in,
   output logic [31:0]      stat_word
);
   import uart_rb_pkg::*;

   localparam int unsigned RXL_FIELD = 7;
   localparam int unsigned TXL_FIELD = 5;

   if (RXL_W < 1 || RXL_W > RXL_FIELD) begin : g_bad_rxl
      $error("uart_rb_stat: RXL_W out of range");
   end
   if (TXL_W < 1 || TXL_W > TXL_FIELD) begin : g_bad_txl
      $error("uart_rb_stat: TXL_W out of range");
   end

   always_comb begin
      stat_word = '0;
      stat_word[SB_RXLVL +: RXL_FIELD] = RXL_FIELD'(rx_level);
      stat_word[SB_TXLVL +: TXL_FIELD] = TXL_FIELD'(tx_room);
      stat_word[SB_TXBSY]              = tx_busy;
      stat_word[SB_RXBSY]              = rx_busy;
      stat_word[SB_RXOVF]              = rx_ovf;
      stat_word[SB_TXOVF]              = tx_ovf;
      stat_word[SB_PAR]                = rx_par_err;
      stat_word[SB_FRM]                = rx_frm_err;
      stat_word[SB_CTS]                = cts_in;
   end

endmodule

// File: rtl/uart_rb_cmd.sv
module uart_rb_cmd (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_we,
   input  logic       clr_we,
   input  logic [2:0] cmd_bits,
   output logic       rts_q,
   output logic       rxrst_q,
   output logic       txrst_q,
   output logic [31:0] cmd_word
);
   import uart_rb_pkg::*;

   localparam int unsigned I_RTS = CMD_RTS   - CMD_LO;
   localparam int unsigned I_RX  = CMD_RXRST - CMD_LO;
   localparam int unsigned I_TX  = CMD_TXRST - CMD_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_q   <= 1'b0;
         rxrst_q <= 1'b0;
         txrst_q <= 1'b0;
      end else begin
         rxrst_q <= set_we & cmd_bits[I_RX];
         txrst_q <= set_we & cmd_bits[I_TX];
         if (set_we && cmd_bits[I_RTS]) begin
            rts_q <= 1'b1;
         end else if (clr_we && cmd_bits[I_RTS]) begin
            rts_q <= 1'b0;
         end
      end
   end

   always_comb begin
      cmd_word            = '0;
      cmd_word[CMD_RTS]   = rts_q;
      cmd_word[CMD_RXRST] = rxrst_q;
      cmd_word[CMD_TXRST] = txrst_q;
   end

   // R10: a set write of the rts bit is visible on the next cycle
   a_r10_rts_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && cmd_bits[I_RTS]) |=> rts_q);

   // R10: a clear write without a set write drops rts on the next cycle
   a_r10_rts_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we && cmd_bits[I_RTS]) |=> !rts_q);

   // R11: a flush pulse only follows a set write with its bit
   a_r11_rx_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      rxrst_q |-> $past(set_we && cmd_bits[I_RX]));

   a_r11_tx_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      txrst_q |-> $past(set_we && cmd_bits[I_TX]));

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq #(
   parameter int unsigned N_SRC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic [N_SRC-1:0] clr,
   input  logic [N_SRC-1:0] mask,
   output logic [N_SRC-1:0] latched,
   output logic [N_SRC-1:0] masked,
   output logic             irq
);

   if (N_SRC < 1 || N_SRC > 16) begin : g_bad_nsrc
      $error("uart_rb_irq: N_SRC must be 1..16");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic prev_q;
      logic lat_q;
      logic rise;

      assign rise = evt[i] & ~prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            lat_q  <= 1'b0;
         end else begin
            prev_q <= evt[i];
            lat_q  <= rise | (lat_q & ~clr[i]);
         end
      end

      assign latched[i] = lat_q;

      // R6: a rising edge of the event always leaves the cause set
      a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && !prev_q) |=> lat_q);

      // R6: no cause appears without a preceding edge
      a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         (!lat_q && !(evt[i] && !prev_q)) |=> !lat_q);

      // R8: a clear with no coincident edge empties the cause
      a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !(evt[i] && !prev_q)) |=> !lat_q);
   end

   assign masked = latched & mask;
   assign irq    = |masked;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned N_SRC  = 10,
   parameter int unsigned RXL_W  = 7,
   parameter int unsigned TXL_W  = 5,
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rx_pop,
   input  logic [CHAR_W-1:0] rx_char,
   output logic              tx_push,
   output logic [CHAR_W-1:0] tx_char,
   input  logic [RXL_W-1:0]  rx_level,
   input  logic [TXL_W-1:0]  tx_room,
   input  logic              tx_busy,
   input  logic              rx_busy,
   input  logic              rx_ovf,
   input  logic              tx_ovf,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              cts_in,
   input  logic [N_SRC-1:0]  irq_evt,
   output logic              ctl_enable,
   output logic              ctl_eight_bits,
   output logic              ctl_two_stop,
   output logic              ctl_par_en,
   output logic [1:0]        ctl_par_kind,
   output logic              ctl_dma_en,
   output logic              ctl_flow_en,
   output logic              ctl_loop,
   output logic [4:0]        trig_rx,
   output logic [3:0]        trig_tx,
   output logic [4:0]        trig_afc,
   output logic              rts,
   output logic              rx_fifo_clr,
   output logic              tx_fifo_clr,
   output logic              irq
);

   localparam int unsigned IDX_LO   = 2;
   localparam int unsigned IDX_W    = $clog2(NUM_REGS);
   localparam int unsigned DEC_TOP  = IDX_LO + IDX_W;

   if (ADDR_W < DEC_TOP) begin : g_bad_addr
      $error("uart_regbank: ADDR_W too small for the register map");
   end
   if (CHAR_W < 1 || CHAR_W > WORD_W) begin : g_bad_char
      $error("uart_regbank: CHAR_W out of range");
   end

   // ---------------- address decode ----------------
   logic                hit;
   logic [IDX_W-1:0]    idx;
   logic [NUM_REGS-1:0] sel_oh;
   logic [NUM_REGS-1:0] we_oh;

   assign hit = bus_sel && (bus_addr[IDX_LO-1:0] == '0) && ((bus_addr >> DEC_TOP) == '0);
   assign idx = bus_addr[IDX_LO +: IDX_W];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
      assign sel_oh[r] = hit && (idx == IDX_W'(r));
      assign we_oh[r]  = sel_oh[r] && bus_wr;
   end

   // ---------------- stored registers ----------------
   logic [31:0]      ctrl_q;
   logic [31:0]      trig_q;
   logic [N_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         trig_q <= '0;
         mask_q <= '0;
      end else begin
         if (we_oh[RS_CTRL]) ctrl_q <= bus_wdata & CTRL_KEEP;
         if (we_oh[RS_TRIG]) trig_q <= bus_wdata & TRIG_KEEP;
         if (we_oh[RS_MASK]) mask_q <= bus_wdata[N_SRC-1:0];
      end
   end

   assign ctl_enable     = ctrl_q[CB_EN];
   assign ctl_eight_bits = ctrl_q[CB_DB8];
   assign ctl_two_stop   = ctrl_q[CB_STOP2];
   assign ctl_par_en     = ctrl_q[CB_PEN];
   assign ctl_par_kind   = ctrl_q[CB_PKIND +: 2];
   assign ctl_dma_en     = ctrl_q[CB_DMA];
   assign ctl_flow_en    = ctrl_q[CB_FLOW];
   assign ctl_loop       = ctrl_q[CB_LOOP];

   assign trig_rx  = trig_q[TB_RX  +: 5];
   assign trig_tx  = trig_q[TB_TX  +: 4];
   assign trig_afc = trig_q[TB_AFC +: 5];

   // ---------------- FIFO data port ----------------
   assign rx_pop  = sel_oh[RS_DATA] & ~bus_wr;
   assign tx_push = we_oh[RS_DATA];
   assign tx_char = bus_wdata[CHAR_W-1:0];

   // ---------------- status ----------------
   logic [31:0] stat_word;

   uart_rb_stat #(
      .RXL_W (RXL_W),
      .TXL_W (TXL_W)
   ) u_stat (
      .rx_level   (rx_level),
      .tx_room    (tx_room),
      .tx_busy    (tx_busy),
      .rx_busy    (rx_busy),
      .rx_ovf     (rx_ovf),
      .tx_ovf     (tx_ovf),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .cts_in     (cts_in),
      .stat_word  (stat_word)
   );

   // ---------------- commands ----------------
   logic [31:0] cmd_word;

   uart_rb_cmd u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (we_oh[RS_CSET]),
      .clr_we   (we_oh[RS_CCLR]),
      .cmd_bits (bus_wdata[CMD_LO +: 3]),
      .rts_q    (rts),
      .rxrst_q  (rx_fifo_clr),
      .txrst_q  (tx_fifo_clr),
      .cmd_word (cmd_word)
   );

   // ---------------- interrupt causes ----------------
   logic [N_SRC-1:0] cause_clr;
   logic [N_SRC-1:0] cause_lat;
   logic [N_SRC-1:0] cause_msk;
   logic [31:0]      cause_word;

   assign cause_clr = we_oh[RS_CAUSE] ?
                      (bus_wdata[N_SRC-1:0] | bus_wdata[CAUSE_RAW +: N_SRC]) : '0;

   uart_rb_irq #(
      .N_SRC (N_SRC)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (irq_evt),
      .clr     (cause_clr),
      .mask    (mask_q),
      .latched (cause_lat),
      .masked  (cause_msk),
      .irq     (irq)
   );

   assign cause_word = 32'(cause_msk) | (32'(cause_lat) << CAUSE_RAW);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit && !bus_wr) begin
         unique case (rb_sel_e'(idx))
            RS_CTRL:  bus_rdata = ctrl_q;
            RS_STAT:  bus_rdata = stat_word;
            RS_DATA:  bus_rdata = 32'(rx_char);
            RS_MASK:  bus_rdata = 32'(mask_q);
            RS_CAUSE: bus_rdata = cause_word;
            RS_TRIG:  bus_rdata = trig_q;
            RS_CSET,
            RS_CCLR:  bus_rdata = cmd_word;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // ---------------- assertions ----------------
   // R9: with every source disabled the interrupt line stays low
   a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   // R4: pop and push never fire together
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_pop && tx_push));

   // R12: misaligned accesses leave control untouched
   a_r12_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_addr[1:0] != 2'b00) |=> $stable(ctrl_q));

   // R2: reserved control bits never become set
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_KEEP) == '0);

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;

   localparam int unsigned NV = 12;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        rx_pop, tx_push;
   logic [7:0]  rx_char, tx_char;
   logic [6:0]  rx_level;
   logic [4:0]  tx_room;
   logic        tx_busy, rx_busy, rx_ovf, tx_ovf, rx_par_err, rx_frm_err, cts_in;
   logic [9:0]  irq_evt;
   logic        ctl_enable, ctl_eight_bits, ctl_two_stop, ctl_par_en;
   logic [1:0]  ctl_par_kind;
   logic        ctl_dma_en, ctl_flow_en, ctl_loop;
   logic [4:0]  trig_rx, trig_afc;
   logic [3:0]  trig_tx;
   logic        rts, rx_fifo_clr, tx_fifo_clr, irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   uart_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_pop(rx_pop), .rx_char(rx_char), .tx_push(tx_push), .tx_char(tx_char),
      .rx_level(rx_level), .tx_room(tx_room), .tx_busy(tx_busy), .rx_busy(rx_busy),
      .rx_ovf(rx_ovf), .tx_ovf(tx_ovf), .rx_par_err(rx_par_err),
      .rx_frm_err(rx_frm_err), .cts_in(cts_in), .irq_evt(irq_evt),
      .ctl_enable(ctl_enable), .ctl_eight_bits(ctl_eight_bits),
      .ctl_two_stop(ctl_two_stop), .ctl_par_en(ctl_par_en),
      .ctl_par_kind(ctl_par_kind), .ctl_dma_en(ctl_dma_en),
      .ctl_flow_en(ctl_flow_en), .ctl_loop(ctl_loop),
      .trig_rx(trig_rx), .trig_tx(trig_tx), .trig_afc(trig_afc),
      .rts(rts), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .irq(irq)
   );

   // {address, write data, expected read-back at the same address}
   localparam logic [68:0] VEC [NV] = '{
      {5'h00, 32'hFFFF_FFFF, 32'h01C0_003F},   // R2 reserved bits dropped
      {5'h00, 32'h0000_0015, 32'h0000_0015},   // R2
      {5'h0C, 32'hFFFF_FFFF, 32'h0000_03FF},   // R7 mask width
      {5'h0C, 32'h0000_0000, 32'h0000_0000},   // R7
      {5'h14, 32'hFFFF_FFFF, 32'h001F_0F1F},   // R5 trigger fields
      {5'h14, 32'h0014_0010, 32'h0014_0010},   // R5
      {5'h04, 32'hFFFF_FFFF, 32'h0000_0000},   // R3 write ignored
      {5'h18, 32'h0000_0020, 32'h0000_0020},   // R10 set rts
      {5'h1C, 32'h0000_0000, 32'h0000_0020},   // R10 zero write keeps rts
      {5'h1C, 32'h0000_0020, 32'h0000_0000},   // R10 clear rts
      {5'h1C, 32'h0000_00C0, 32'h0000_0000},   // R11 clear reg ignores flush bits
      {5'h00, 32'h0000_0000, 32'h0000_0000}    // R2
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write took effect
   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // called at a falling edge; samples 1 ns later, ends at the next falling edge
   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   initial begin
      #(4 * 50000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] exp_stat;
      rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
      rx_char = '0; rx_level = '0; tx_room = '0; tx_busy = 0; rx_busy = 0;
      rx_ovf = 0; tx_ovf = 0; rx_par_err = 0; rx_frm_err = 0; cts_in = 0; irq_evt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(5'h00, rd); chk("R1 ctrl", rd, 32'h0);
      bus_read(5'h0C, rd); chk("R1 mask", rd, 32'h0);
      bus_read(5'h14, rd); chk("R1 trig", rd, 32'h0);
      bus_read(5'h18, rd); chk("R1 cmd", rd, 32'h0);
      bus_read(5'h10, rd); chk("R1 cause", rd, 32'h0);
      chk("R1 outs", {28'h0, irq, rts, rx_fifo_clr, tx_fifo_clr}, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][68:64], VEC[i][63:32]);
         bus_read(VEC[i][68:64], rd);
         chk($sformatf("table[%0d] R2/R3/R5/R7/R10/R11", i), rd, VEC[i][31:0]);
      end

      // R2 decoded control outputs
      bus_write(5'h00, 32'h01C0_0035);
      chk("R2 ctl outs",
          {24'h0, ctl_enable, ctl_eight_bits, ctl_two_stop, ctl_par_en,
           ctl_par_kind, ctl_dma_en, ctl_flow_en},
          {24'h0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1});
      chk("R2 loop", {31'h0, ctl_loop}, 32'h1);

      // R5 trigger outputs
      bus_write(5'h14, 32'h0011_0A07);
      chk("R5 trig outs", {18'h0, trig_afc, trig_tx, trig_rx}, {18'h0, 5'h11, 4'hA, 5'h07});

      // R3 status packing
      rx_level = 7'h55; tx_room = 5'h13; tx_busy = 1; rx_busy = 0; rx_ovf = 1;
      tx_ovf = 0; rx_par_err = 1; rx_frm_err = 0; cts_in = 1;
      exp_stat = 32'h55 | (32'h13 << 8) | (32'h1 << 14) | (32'h1 << 16)
               | (32'h1 << 18) | (32'h1 << 25);
      bus_read(5'h04, rd); chk("R3 status A", rd, exp_stat);
      rx_level = 7'h00; tx_room = 5'h00; tx_busy = 0; rx_busy = 1; rx_ovf = 0;
      tx_ovf = 1; rx_par_err = 0; rx_frm_err = 1; cts_in = 0;
      bus_read(5'h04, rd); chk("R3 status B", rd, (32'h1 << 15) | (32'h1 << 17) | (32'h1 << 19));

      // R4 data pop / push
      rx_char = 8'hA7;
      bus_sel = 1; bus_wr = 0; bus_addr = 5'h08;
      #1;
      chk("R4 read data", bus_rdata, 32'hA7);
      chk("R4 pop", {31'h0, rx_pop}, 32'h1);
      @(negedge clk);
      bus_wr = 1; bus_wdata = 32'h1234_5678;
      #1;
      chk("R4 push", {23'h0, tx_push, tx_char}, {23'h0, 1'b1, 8'h78});
      chk("R4 no pop on write", {31'h0, rx_pop}, 32'h0);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;

      // R6 / R7 latch with mask off
      irq_evt = 10'h002;
      @(negedge clk);
      bus_read(5'h10, rd); chk("R6/R7 raw only", rd, 32'h0002_0000);
      chk("R9 irq masked off", {31'h0, irq}, 32'h0);
      bus_write(5'h0C, 32'h0000_0002);
      bus_read(5'h10, rd); chk("R7 both halves", rd, 32'h0002_0002);
      chk("R9 irq on", {31'h0, irq}, 32'h1);

      // R8 clear via low half, R6 held level does not relatch
      bus_write(5'h10, 32'h0000_0002);
      chk("R8 irq after clear", {31'h0, irq}, 32'h0);
      repeat (3) @(negedge clk);
      bus_read(5'h10, rd); chk("R6 no relatch", rd, 32'h0);

      // R8 edge coincident with clear (high half) keeps cause
      irq_evt = 10'h00A;
      bus_write(5'h10, 32'h0008_0000);
      bus_read(5'h10, rd); chk("R8 set beats clear", rd, 32'h0008_0000);

      // R9 masking drops irq, cause stays
      bus_write(5'h0C, 32'h0000_0008);
      chk("R9 irq enabled", {31'h0, irq}, 32'h1);
      bus_write(5'h0C, 32'h0000_0000);
      chk("R9 irq masked", {31'h0, irq}, 32'h0);
      bus_read(5'h10, rd); chk("R9 cause kept", rd, 32'h0008_0000);
      irq_evt = '0;

      // R11 flush pulses
      bus_write(5'h18, 32'h0000_0040);
      chk("R11 rx pulse", {30'h0, rx_fifo_clr, tx_fifo_clr}, 32'h2);
      @(negedge clk);
      chk("R11 rx pulse ends", {30'h0, rx_fifo_clr, tx_fifo_clr}, 32'h0);
      bus_write(5'h18, 32'h0000_0080);
      chk("R11 tx pulse", {30'h0, rx_fifo_clr, tx_fifo_clr}, 32'h1);
      @(negedge clk);
      bus_read(5'h18, rd); chk("R11 reads 0", rd, 32'h0);
      bus_write(5'h1C, 32'h0000_00C0);
      chk("R11 clear reg no pulse", {30'h0, rx_fifo_clr, tx_fifo_clr}, 32'h0);

      // R12 misaligned accesses ignored
      bus_write(5'h00, 32'h0000_0001);
      bus_write(5'h01, 32'h0000_0006);
      bus_read(5'h00, rd); chk("R12 ctrl unchanged", rd, 32'h1);
      bus_read(5'h02, rd); chk("R12 misaligned read", rd, 32'h0);
      bus_sel = 1; bus_wr = 0; bus_addr = 5'h09;
      #1 chk("R12 no pop", {31'h0, rx_pop}, 32'h0);
      @(negedge clk);
      bus_sel = 0;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule